// File: doc/BRIEF.md
# Sticky Fault Status Register with Echo-Reset Clearing

This block holds one 8-bit status register for one powered slot. Three fault bits capture fault events (auxiliary over-current, 12 V fault, 3.3 V fault) and hold them after the condition has gone. Three level bits show the live state of the slot's fault pin, main supply good and auxiliary supply good. An active-low interrupt stays asserted while any captured fault bit is set. A host reaches the register through a plain read strobe and a plain write strobe with write data, as a serial bus slave would present it after decoding its own framing.

Captured faults are cleared by an echo-reset handshake. The host writes a 1 to a fault bit that is set. This does not clear the bit. It arms a clear. The next read of the register then removes the bit, but only if the live fault is gone at that read. If the fault is still present, the armed clear is dropped and the host has to echo the bit again. Read data is combinational from the current state, so the read cycle itself still returns the bit as set. The clear takes effect at the clock edge that ends the read. The read and write strobes are plain, single-cycle qualifiers. There is no back-pressure: every strobe is taken in the cycle it is high.

Top module: `fault_echo_status`

## Requirements
- R1: Bit layout of `rd_data`: bit 7 reads 1 while `slot_fault_n` is low. Bit 6 shows `main_good`, bit 5 shows `aux_good`, bit 4 is the sticky auxiliary over-current fault, bit 2 the sticky 12 V fault and bit 0 the sticky 3.3 V fault. Bits 3 and 1 always read 0.
- R2: While `rst_n` is low, all sticky bits and armed clears are zero and `irq_n` is high.
- R3: A fault input that is high at a clock edge sets its sticky bit, at bit 4, 2 or 0. The bit stays set until it is cleared by R5.
- R4: An accepted write with a 1 in bit 4, 2 or 0 arms a clear for that bit, but only if the bit is set. The write never changes the read value by itself.
- R5: A read (`rd_en` high) of a bit with an armed clear, while its fault input is low, clears that bit at the edge that ends the read. The read data in that cycle still shows the bit as 1.
- R6: A read of an armed bit whose fault input is still high leaves the bit set and discards the armed clear. A later read without a new echo write does not clear the bit.
- R7: A write whose data has any bit set outside bits 4, 2 and 0 is ignored. It arms nothing and leaves existing armed clears unchanged. The accepted values are 00h, 01h, 04h, 05h, 10h, 11h, 14h and 15h.
- R8: `irq_n` is low whenever any sticky bit is set. It returns high once all sticky bits have been cleared.
- R9: A rising edge of a fault input cancels the armed clear of that bit.
- R10: When a read and an accepted write fall in the same cycle, the read uses only the clears armed before that cycle. The clears armed by the write act at the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| slot_fault_n | input | 1 | Level of the slot's active-low fault pin |
| main_good | input | 1 | Main supplies in power-good state |
| aux_good | input | 1 | Auxiliary supply in power-good state |
| aux_oc_fault | input | 1 | Live auxiliary over-current condition |
| v12_fault | input | 1 | Live 12 V fault condition |
| v33_fault | input | 1 | Live 3.3 V fault condition |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Three pairs of functions can meet in one cycle: a read and an echo write, a read and a live fault, and a fault rising edge and a clear that is already armed. The directed phase forces each pair in one cycle. It checks that a read together with a write of another bit clears only the bit armed earlier. It checks that a read while the fault persists keeps the bit, and that a fault pulse after an echo leaves the bit uncleared at the next read. A random phase then drives strobes, writes and fault levels at the same time. A behavioural model in the bench judges `rd_data` and `irq_n` on every clock.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_FLT   = 3;
  localparam int unsigned FLT_STEP  = 2;
  localparam int unsigned POS_PIN   = 7;
  localparam int unsigned POS_MAIN  = 6;
  localparam int unsigned POS_AUX   = 5;

  // bit position of fault index i (0: 3.3 V, 1: 12 V, 2: aux over-current)
  function automatic int unsigned flt_pos(input int unsigned idx);
    return FLT_STEP * idx;
  endfunction

  function automatic logic [REG_W-1:0] wr_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_FLT; i++) m[flt_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fes_wr_decode.sv
module fes_wr_decode
  import fes_pkg::*;
#(
  parameter int unsigned DW = REG_W,
  parameter int unsigned NF = NUM_FLT
) (
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [NF-1:0] arm_req
);
  localparam logic [DW-1:0] MASK = DW'(wr_mask());

  logic accept;
  assign accept = wr_en && ((wr_data & ~MASK) == '0);

  for (genvar g = 0; g < NF; g++) begin : g_req
    assign arm_req[g] = accept && wr_data[flt_pos(g)];
  end
endmodule

// File: rtl/fes_sticky_cell.sv
module fes_sticky_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic rd_en,
  input  logic arm_req,
  output logic flag
);
  logic armed;
  logic fault_q;
  logic clr;
  logic rise;
  logic armed_nxt;

  assign clr  = rd_en && armed && !fault;
  assign rise = fault && !fault_q;

  always_comb begin
    armed_nxt = armed && !rd_en;
    if (arm_req && flag) armed_nxt = 1'b1;
    if (rise) armed_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      flag    <= (flag && !clr) || fault;
      armed   <= armed_nxt;
      fault_q <= fault;
    end
  end
endmodule

// File: rtl/fes_view.sv
module fes_view
  import fes_pkg::*;
#(
  parameter int unsigned DW = REG_W,
  parameter int unsigned NF = NUM_FLT
) (
  input  logic          slot_fault_n,
  input  logic          main_good,
  input  logic          aux_good,
  input  logic [NF-1:0] flags,
  output logic [DW-1:0] rd_data,
  output logic          irq_n
);
  always_comb begin
    rd_data           = '0;
    rd_data[POS_PIN]  = !slot_fault_n;
    rd_data[POS_MAIN] = main_good;
    rd_data[POS_AUX]  = aux_good;
    for (int unsigned i = 0; i < NF; i++) rd_data[flt_pos(i)] = flags[i];
  end

  assign irq_n = !(|flags);
endmodule

// File: rtl/fault_echo_status.sv
module fault_echo_status
  import fes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_fault_n,
  input  logic             main_good,
  input  logic             aux_good,
  input  logic             aux_oc_fault,
  input  logic             v12_fault,
  input  logic             v33_fault,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_n
);
  logic [NUM_FLT-1:0] live;
  logic [NUM_FLT-1:0] arm_req;
  logic [NUM_FLT-1:0] flags;

  assign live = {aux_oc_fault, v12_fault, v33_fault};

  fes_wr_decode #(.DW(REG_W), .NF(NUM_FLT)) i_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .arm_req (arm_req)
  );

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_cell
    fes_sticky_cell i_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .fault   (live[g]),
      .rd_en   (rd_en),
      .arm_req (arm_req[g]),
      .flag    (flags[g])
    );
  end

  fes_view #(.DW(REG_W), .NF(NUM_FLT)) i_view (
    .slot_fault_n (slot_fault_n),
    .main_good    (main_good),
    .aux_good     (aux_good),
    .flags        (flags),
    .rd_data      (rd_data),
    .irq_n        (irq_n)
  );
endmodule

// File: rtl/fes_checker.sv
module fes_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       aux_oc_fault,
  input logic       v12_fault,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       irq_n
);
  // R2: reset state
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_clear_r2: assert ((rd_data & 8'h15) == 8'h00 && irq_n)
        else $error("sticky bits or irq not cleared in reset");
    end
  end

  // R3: a set fault bit never drops without a read
  p_hold_without_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((rd_data & $past(rd_data) & 8'h15) == ($past(rd_data) & 8'h15)));

  // R3: a live fault sets its bit at the edge
  p_fault_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aux_oc_fault |=> rd_data[4]);

  // R6: a read while the fault persists keeps the bit
  p_keep_if_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && v12_fault) |=> rd_data[2]);

  // R8: the interrupt can only release after a read
  p_irq_release_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(rd_en));
endmodule

bind fault_echo_status fes_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .aux_oc_fault (aux_oc_fault),
  .v12_fault    (v12_fault),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .irq_n        (irq_n)
);

// File: tb/test_fault_echo_status.sv
module test_fault_echo_status;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_fault_n = 1'b1;
  logic       main_good = 1'b0, aux_good = 1'b0;
  logic       aux_oc_fault = 1'b0, v12_fault = 1'b0, v33_fault = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_echo_status i_fault_echo_status (
    .clk(clk), .rst_n(rst_n), .slot_fault_n(slot_fault_n),
    .main_good(main_good), .aux_good(aux_good),
    .aux_oc_fault(aux_oc_fault), .v12_fault(v12_fault), .v33_fault(v33_fault),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // behavioural reference: index 0 = 3.3 V (bit0), 1 = 12 V (bit2), 2 = aux OC (bit4)
  bit m_stk[3];
  bit m_arm[3];
  bit m_prev[3];

  function automatic bit live_of(int i);
    if (i == 0) return v33_fault;
    if (i == 1) return v12_fault;
    return aux_oc_fault;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_stk[i]) begin m_stk[i] = 0; m_arm[i] = 0; m_prev[i] = 0; end
    end else begin
      bit ok;
      ok = wr_en && ((wr_data & 8'hEA) == 8'h00);
      foreach (m_stk[i]) begin
        bit f, was_set, next_arm;
        f = live_of(i);
        was_set = m_stk[i];
        next_arm = rd_en ? 1'b0 : m_arm[i];
        if (ok && wr_data[2*i] && was_set) next_arm = 1'b1;
        if (f && !m_prev[i]) next_arm = 1'b0;
        if (rd_en && m_arm[i] && !f) m_stk[i] = 1'b0;
        if (f) m_stk[i] = 1'b1;
        m_arm[i] = next_arm;
        m_prev[i] = f;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every clock (R1 layout, R3 sticky, R8 interrupt)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp;
      exp = {~slot_fault_n, main_good, aux_good, m_stk[2], 1'b0, m_stk[1], 1'b0, m_stk[0]};
      chk("R1/R3 model rd_data", rd_data, exp);
      chk("R8 model irq_n", {7'd0, irq_n}, {7'd0, !(m_stk[0] | m_stk[1] | m_stk[2])});
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic rd();
    rd_en = 1'b1; cyc(); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > WATCHDOG && !done) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cnt, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    cyc(3);
    chk("R2 reset rd_data", rd_data, 8'h00);
    chk("R2 reset irq_n", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    cyc();

    // R1: level bits
    main_good = 1; aux_good = 1; slot_fault_n = 0; cyc();
    chk("R1 live bits", rd_data, 8'hE0);
    slot_fault_n = 1; main_good = 0; cyc();
    chk("R1 live bits 2", rd_data, 8'h20);

    // R3 + R8: sticky 3.3 V
    v33_fault = 1; cyc(); v33_fault = 0; cyc(3);
    chk("R3 sticky bit0", rd_data, 8'h21);
    chk("R8 irq asserted", {7'd0, irq_n}, 8'h00);

    // R4: echo write arms only
    wr(8'h01);
    chk("R4 write no direct clear", rd_data, 8'h21);

    // R5: read clears, read cycle still shows 1
    rd_en = 1'b1;
    chk("R5 read cycle shows set", rd_data, 8'h21);
    cyc(); rd_en = 1'b0;
    chk("R5 cleared after read", rd_data, 8'h20);
    chk("R8 irq released", {7'd0, irq_n}, 8'h01);

    // R6: read while fault persists
    v12_fault = 1; cyc(); wr(8'h04); rd(); v12_fault = 0; cyc();
    chk("R6 kept while present", rd_data, 8'h24);
    rd();
    chk("R6 arm discarded", rd_data, 8'h24);
    wr(8'h04); rd();
    chk("R6 re-echo clears", rd_data, 8'h20);

    // R7: bad write ignored
    aux_oc_fault = 1; cyc(); aux_oc_fault = 0; cyc();
    wr(8'h17); rd();
    chk("R7 bad write ignored", rd_data, 8'h30);
    wr(8'h10); wr(8'h80); rd();
    chk("R7 bad write keeps arm", rd_data, 8'h20);

    // R9: fault edge cancels arm
    v33_fault = 1; cyc(); v33_fault = 0; cyc();
    wr(8'h01); v33_fault = 1; cyc(); v33_fault = 0; cyc(); rd();
    chk("R9 edge cancels arm", rd_data, 8'h21);

    // R10: read and write in one cycle
    v12_fault = 1; cyc(); v12_fault = 0; cyc();
    wr(8'h01);
    rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h04; cyc();
    rd_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    chk("R10 only earlier arm used", rd_data, 8'h24);
    rd();
    chk("R10 same-cycle arm used next", rd_data, 8'h20);
    chk("R8 irq high after all clear", {7'd0, irq_n}, 8'h01);

    // random phase, judged by the model every clock
    for (int k = 0; k < 2000; k++) begin
      slot_fault_n = $urandom_range(0, 1);
      main_good    = $urandom_range(0, 1);
      aux_good     = $urandom_range(0, 1);
      aux_oc_fault = ($urandom_range(0, 7) == 0);
      v12_fault    = ($urandom_range(0, 7) == 0);
      v33_fault    = ($urandom_range(0, 7) == 0);
      rd_en        = ($urandom_range(0, 3) == 0);
      wr_en        = ($urandom_range(0, 2) == 0);
      wr_data      = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (8'($urandom) & 8'h15);
      cyc();
    end
    rd_en = 0; wr_en = 0;
    cyc(2);
    finish_run();
  end
endmodule